// File: doc/BRIEF.md
# Line Clamp Pulse Generator

This block produces one active-high clamp pulse per horizontal line for a display front end. It watches an already normalised, active-high horizontal sync signal and, depending on a two-bit position select, fires on either the leading (rising) edge or the trailing (falling) edge of that sync. A third setting lets the block choose the edge itself from the kind of sync source: a separate or composite sync source takes the leading edge, and a sync carried on the video signal takes the trailing edge.

The pulse length is set in clock cycles by a programmable width input. A counter takes the place of an RC timing network. Widths below a floor of one quarter of the nominal width are raised to that floor. The width and the edge choice are taken once, at the trigger. A sync edge that arrives while a pulse is still running is dropped, so the running pulse is never stretched or restarted.

Top module: `clamp_pulse_gen`

## Requirements
- R1: After synchronous reset the clamp output is low, and it stays low until a selected sync edge is seen after reset.
- R2: With the position select at 2'b01, a rising edge of the sync input starts a pulse. The output goes high in the cycle after the clock edge that first samples the sync high.
- R3: With the position select at 2'b00, a falling edge of the sync input starts a pulse. The output goes high in the cycle after the clock edge that first samples the sync low.
- R4: With the position select at 2'b10 or 2'b11, the rising edge is used when the source input is 0 (separate or composite sync), and the falling edge is used when the source input is 1 (sync on video).
- R5: A pulse is high for exactly the programmed width in clock cycles, as one unbroken run, whenever that width is at least the floor.
- R6: A programmed width below the floor MIN_WIDTH = NOM_WIDTH/4 (10 cycles with the default NOM_WIDTH of 40), including zero, gives a pulse of exactly MIN_WIDTH cycles.
- R7: A selected edge that arrives while a pulse is high is ignored. The pulse is neither extended nor restarted.
- R8: Changes to the width or the position select while a pulse is high do not change the length of that pulse.
- R9: Sync edges of the polarity that is not selected produce no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_in | input | 1 | Normalised horizontal sync, active high |
| pos_sel | input | 2 | Edge position: 01 leading, 00 trailing, 1x automatic |
| src_video | input | 1 | Source kind: 0 separate/composite sync, 1 sync on video |
| width_cfg | input | CNT_W (8) | Pulse width in clock cycles |
| clamp_out | output | 1 | Clamp pulse, active high |

## Verification
The bench measures the first high cycle and the high-cycle count of each pulse against the sync edges. A design that fired on the wrong edge would show a start offset equal to the sync high time instead of zero, or the reverse. The bench programs widths of 0 and 3 and expects the floor length. A design without the floor would give a runt or missing pulse. A second rising edge is applied mid-pulse, and the width and the mode are changed mid-pulse. A design that retriggers or reads the width live would give a longer pulse, or a second pulse on the trailing edge.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

    typedef enum logic {
        EDGE_LEAD  = 1'b0,
        EDGE_TRAIL = 1'b1
    } trig_edge_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } sync_edges_t;

    // Position select: 01 leading, 00 trailing, 1x automatic by source kind.
    function automatic trig_edge_e pick_edge(input logic [1:0] sel, input logic src_video);
        trig_edge_e e;
        if (sel[1]) begin
            e = src_video ? EDGE_TRAIL : EDGE_LEAD;
        end else if (sel[0]) begin
            e = EDGE_LEAD;
        end else begin
            e = EDGE_TRAIL;
        end
        return e;
    endfunction

endpackage

// File: rtl/clamp_edge_det.sv
module clamp_edge_det
    import clamp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        hsync_in,
    output sync_edges_t edges
);
    logic hs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q <= 1'b0;
        end else begin
            hs_q <= hsync_in;
        end
    end

    always_comb begin
        edges.rise = hsync_in & ~hs_q;
        edges.fall = ~hsync_in & hs_q;
    end

endmodule

// File: rtl/clamp_trig_sel.sv
module clamp_trig_sel
    import clamp_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int MIN_WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  sync_edges_t      edges,
    input  logic [1:0]       pos_sel,
    input  logic             src_video,
    input  logic [CNT_W-1:0] width_cfg,
    output logic             trig,
    output logic [CNT_W-1:0] w_eff
);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_WIDTH);

    trig_edge_e sel_edge;

    always_comb begin
        sel_edge = pick_edge(pos_sel, src_video);
        trig     = (sel_edge == EDGE_LEAD) ? edges.rise : edges.fall;
        w_eff    = (width_cfg < FLOOR) ? FLOOR : width_cfg;
    end

    // R6: every width handed on with a trigger respects the floor
    assert_width_floor_R6: assert property (@(posedge clk) disable iff (rst)
        trig |-> (w_eff >= FLOOR));

    // R4: automatic mode on a video source never fires on a rising edge
    assert_auto_video_R4: assert property (@(posedge clk) disable iff (rst)
        (pos_sel[1] && src_video && edges.rise) |-> !trig);

    // R9: a trailing-only setting ignores rising edges
    assert_back_no_rise_R9: assert property (@(posedge clk) disable iff (rst)
        (pos_sel == 2'b00 && edges.rise) |-> !trig);

endmodule

// File: rtl/clamp_pulse_timer.sv
module clamp_pulse_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic [CNT_W-1:0] w_load,
    output logic             pulse
);
    logic [CNT_W-1:0] remain;
    logic             busy;

    assign busy  = (remain != '0);
    assign pulse = busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (trig && !busy) begin
            remain <= w_load;
        end else if (busy) begin
            remain <= remain - CNT_W'(1);
        end
    end

    // R5: an accepted trigger loads the width captured in that cycle
    assert_load_width_R5: assert property (@(posedge clk) disable iff (rst)
        (trig && !busy) |=> (remain == $past(w_load)));

    // R7: a trigger during a pulse only lets the count run down
    assert_no_retrig_R7: assert property (@(posedge clk) disable iff (rst)
        (trig && busy) |=> (remain == $past(remain) - CNT_W'(1)));

endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
    import clamp_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int NOM_WIDTH = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hsync_in,
    input  logic [1:0]       pos_sel,
    input  logic             src_video,
    input  logic [CNT_W-1:0] width_cfg,
    output logic             clamp_out
);
    localparam int MIN_WIDTH = NOM_WIDTH / 4;

    sync_edges_t      edges;
    logic             trig;
    logic [CNT_W-1:0] w_eff;

    clamp_edge_det u_edge (
        .clk      (clk),
        .rst      (rst),
        .hsync_in (hsync_in),
        .edges    (edges)
    );

    clamp_trig_sel #(
        .CNT_W     (CNT_W),
        .MIN_WIDTH (MIN_WIDTH)
    ) u_sel (
        .clk       (clk),
        .rst       (rst),
        .edges     (edges),
        .pos_sel   (pos_sel),
        .src_video (src_video),
        .width_cfg (width_cfg),
        .trig      (trig),
        .w_eff     (w_eff)
    );

    clamp_pulse_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .trig   (trig),
        .w_load (w_eff),
        .pulse  (clamp_out)
    );

    // R1: the output only rises after a trigger in the preceding cycle
    assert_rise_needs_trig_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(clamp_out) |-> $past(trig));

endmodule

// File: tb/clamp_pulse_gen_tb.sv
module clamp_pulse_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int NOM        = 40;
    localparam int MINW       = NOM / 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             hsync_in = 1'b0;
    logic [1:0]       pos_sel = 2'b01;
    logic             src_video = 1'b0;
    logic [CNT_W-1:0] width_cfg = 8'd20;
    logic             clamp_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clamp_pulse_gen #(.CNT_W(CNT_W), .NOM_WIDTH(NOM)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .hsync_in  (hsync_in),
        .pos_sel   (pos_sel),
        .src_video (src_video),
        .width_cfg (width_cfg),
        .clamp_out (clamp_out)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One sync line: rise, hold hi_len samples, fall; optional second rise and
    // mid-pulse config change. Measures the first high index and high count.
    task automatic run_line(input string req, input logic [1:0] sel, input logic vid,
                            input int width, input int hi_len, input int total,
                            input int rerise_at, input int chg_at,
                            input int exp_first, input int exp_cnt);
        int first = -1;
        int cnt = 0;
        int last = -1;
        pos_sel   = sel;
        src_video = vid;
        width_cfg = CNT_W'(width);
        hsync_in  = 1'b1;
        for (int i = 0; i < total; i++) begin
            @(negedge clk);
            if (clamp_out) begin
                if (first < 0) first = i;
                last = i;
                cnt++;
            end
            if (i == hi_len - 1) hsync_in = 1'b0;
            if (rerise_at >= 0 && i == rerise_at - 1) hsync_in = 1'b1;
            if (rerise_at >= 0 && i == rerise_at + 1) hsync_in = 1'b0;
            if (chg_at >= 0 && i == chg_at) begin
                width_cfg = 8'd60;
                pos_sel   = 2'b00;
            end
        end
        check(req, first, exp_first, "first high index");
        check(req, cnt, exp_cnt, "high cycles");
        check(req, (cnt == 0) ? 0 : last - first + 1, exp_cnt, "contiguous span");
        hsync_in = 1'b0;
        idle(4);
        check(req, int'(clamp_out), 0, "idle after line");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", int'(clamp_out), 0, "during reset");
        rst = 1'b0;
        idle(5);
        check("R1", int'(clamp_out), 0, "idle after reset");

        // R2 leading edge, R5 width
        run_line("R2", 2'b01, 1'b0, 20, 8, 60, -1, -1, 0, 20);
        // R3 trailing edge; R9 rising edge gives nothing (start offset = hi_len)
        run_line("R3", 2'b00, 1'b0, 20, 8, 60, -1, -1, 8, 20);
        run_line("R9", 2'b00, 1'b1, 15, 12, 60, -1, -1, 12, 15);
        // R4 automatic selection
        run_line("R4", 2'b10, 1'b0, 20, 8, 60, -1, -1, 0, 20);
        run_line("R4", 2'b11, 1'b1, 20, 8, 60, -1, -1, 8, 20);
        run_line("R4", 2'b11, 1'b0, 20, 8, 60, -1, -1, 0, 20);
        // R5 widths
        run_line("R5", 2'b01, 1'b0, 37, 5, 70, -1, -1, 0, 37);
        run_line("R5", 2'b01, 1'b0, MINW, 5, 40, -1, -1, 0, MINW);
        // R6 floor
        run_line("R6", 2'b01, 1'b0, 3, 5, 40, -1, -1, 0, MINW);
        run_line("R6", 2'b00, 1'b0, 0, 5, 40, -1, -1, 5, MINW);
        // R7 second rising edge mid-pulse ignored
        run_line("R7", 2'b01, 1'b0, 30, 3, 70, 6, -1, 0, 30);
        // R8 width and mode changed mid-pulse: length unchanged, later fall ignored
        run_line("R8", 2'b01, 1'b0, 20, 8, 90, -1, 4, 0, 20);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule